// File: doc/BRIEF.md
# Timestamped Cross-Pipe Hazard Table

This block keeps a small fixed-depth table of the resources the render pipe currently has in use. Each entry holds an opaque 64-bit handle, a write flag and the timestamp of the last use. The binning pipe inserts render-side resources through the insert port. It asks whether a binning-side resource may proceed through the check port, which holds its ready low while a conflicting entry is present.

Entries leave the table in bulk. A completion event carries the current timestamp, and when its clear flag is set every entry stamped at or before that value is dropped. An insert into a full table sets a sticky overflow flag instead of blocking. Software clears that flag by writing zero, and the binning pipe is expected to fall back to serial operation while it is set.

Top module: `hazard_table`

## Requirements
- R1: After reset the table is empty, so `chk_ready` is 1 for any handle and mode, and `ovf_flag` is 0.
- R2: `chk_ready` is 0 in the same cycle whenever a valid entry has a handle equal to `chk_handle` (all 64 bits compared) and either that entry's write flag or `chk_write` is 1. It returns to 1 in the cycle after the edge that removes the last such entry.
- R3: A check with `chk_write`=0 is never stalled by entries whose write flag is 0.
- R4: A check never changes the table. A handle that was only checked causes no later stall.
- R5: An insert with no matching entry and a free slot adds an entry with the given handle, write flag and stamp, visible from the next cycle.
- R6: An insert whose handle matches a surviving entry replaces that entry's stamp with `ins_stamp` and ORs `ins_write` into its write flag. It uses no new slot.
- R7: An insert with no matching entry while all DEPTH slots survive sets `ovf_flag` to 1 on the next edge and adds nothing.
- R8: `ovf_flag` stays 1 until a cycle with `ovf_wr`=1 and `ovf_wdata`=0. A write with `ovf_wdata`=1 has no effect, and an overflow in the same cycle as a clearing write leaves the flag at 1.
- R9: With `ret_valid`=1 and `ret_clear`=1, every entry whose stamp is less than or equal to `ret_stamp` is removed. The comparison is unsigned with no wraparound, and larger stamps are kept.
- R10: A completion with `ret_clear`=0 removes nothing.
- R11: When a retire and an insert share a cycle, the retire acts on the entries present before the edge. The insert matches and allocates against the survivors, and a newly written entry or stamp is not removed by that retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a render-side resource this cycle |
| ins_handle | input | 64 | Opaque handle to insert |
| ins_write | input | 1 | Inserted resource is written |
| ins_stamp | input | 32 | Timestamp of this use |
| chk_valid | input | 1 | Binning-side check request present |
| chk_handle | input | 64 | Handle to check |
| chk_write | input | 1 | Checked resource is written |
| chk_ready | output | 1 | No conflicting entry; the check may complete |
| ret_valid | input | 1 | Completion event this cycle |
| ret_clear | input | 1 | Completion clears render resources |
| ret_stamp | input | 32 | Completed timestamp |
| ovf_wr | input | 1 | Software write to the overflow flag |
| ovf_wdata | input | 1 | Written value; 0 clears the flag |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
The bench probes the retire boundary from both sides. An entry stamped exactly at the completion value must leave the table, one stamped a step later must stay, and a stamp near the top of the range must survive a small completion value. A design with an off-by-one compare or a wrapping compare would then show a stall that is released too early or never released. The bench merges repeated inserts of the same handle into a full table and requires the overflow flag to stay clear. A design that allocates a duplicate slot would raise the flag early, and a design that keeps the old stamp would release on an early retire. Handles that differ only in their top bit, and a retire in the same cycle as an insert, expose truncated comparisons and wrong ordering between removal and allocation.

// File: rtl/hazard_table.sv
module hazard_table #(
  parameter int DEPTH = 8,
  parameter int HW    = 64,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [HW-1:0] ins_handle,
  input  logic          ins_write,
  input  logic [TW-1:0] ins_stamp,
  input  logic          chk_valid,
  input  logic [HW-1:0] chk_handle,
  input  logic          chk_write,
  output logic          chk_ready,
  input  logic          ret_valid,
  input  logic          ret_clear,
  input  logic [TW-1:0] ret_stamp,
  input  logic          ovf_wr,
  input  logic          ovf_wdata,
  output logic          ovf_flag
);

  logic [DEPTH-1:0]         vld_q, wr_q;
  logic [DEPTH-1:0][HW-1:0] hdl_q;
  logic [DEPTH-1:0][TW-1:0] ts_q;

  logic [DEPTH-1:0] kill, keep, ins_hit, chk_hit, free, alloc;
  logic             any_hit, full, ins_new, ovf_set;

  wire sweep = ret_valid & ret_clear;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign kill[i]    = sweep & vld_q[i] & (ts_q[i] <= ret_stamp);
    assign keep[i]    = vld_q[i] & ~kill[i];
    assign ins_hit[i] = keep[i] & (hdl_q[i] == ins_handle);
    assign chk_hit[i] = vld_q[i] & (hdl_q[i] == chk_handle) & (wr_q[i] | chk_write);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        wr_q[i]  <= 1'b0;
        hdl_q[i] <= '0;
        ts_q[i]  <= '0;
      end else if (ins_valid && ins_hit[i]) begin
        ts_q[i] <= ins_stamp;
        wr_q[i] <= wr_q[i] | ins_write;
      end else if (ins_new && alloc[i]) begin
        vld_q[i] <= 1'b1;
        wr_q[i]  <= ins_write;
        hdl_q[i] <= ins_handle;
        ts_q[i]  <= ins_stamp;
      end else begin
        vld_q[i] <= keep[i];
      end
    end
  end

  assign free     = ~keep;
  assign alloc    = free & (~free + 1'b1);
  assign any_hit  = |ins_hit;
  assign full     = &keep;
  assign ins_new  = ins_valid & ~any_hit & ~full;
  assign ovf_set  = ins_valid & ~any_hit & full;

  assign chk_ready = ~|chk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                ovf_flag <= 1'b0;
    else if (ovf_set)          ovf_flag <= 1'b1;
    else if (ovf_wr && !ovf_wdata) ovf_flag <= 1'b0;
  end

endmodule

// File: rtl/hazard_table_chk.sv
module hazard_table_chk #(
  parameter int DEPTH = 8,
  parameter int HW    = 64,
  parameter int TW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ins_valid,
  input logic                     chk_valid,
  input logic [HW-1:0]            chk_handle,
  input logic                     chk_write,
  input logic                     chk_ready,
  input logic                     ret_valid,
  input logic                     ret_clear,
  input logic [TW-1:0]            ret_stamp,
  input logic                     ovf_wr,
  input logic                     ovf_wdata,
  input logic                     ovf_flag,
  input logic [DEPTH-1:0]         vld_q,
  input logic [DEPTH-1:0]         wr_q,
  input logic [DEPTH-1:0][HW-1:0] hdl_q,
  input logic [DEPTH-1:0][TW-1:0] ts_q
);

  logic [DEPTH-1:0] same, same_wr, stale;
  logic             fire_d;
  logic [TW-1:0]    stamp_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      same[i]    = vld_q[i] && hdl_q[i] == chk_handle;
      same_wr[i] = same[i] && wr_q[i];
      stale[i]   = vld_q[i] && ts_q[i] <= stamp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_d  <= 1'b0;
      stamp_d <= '0;
    end else begin
      fire_d  <= ret_valid && ret_clear && !ins_valid;
      stamp_d <= ret_stamp;
    end
  end

  // R2
  wr_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_write && (|same) |-> !chk_ready);

  // R3
  read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_write && !(|same_wr) |-> chk_ready);

  // R4
  no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $countones(vld_q) <= $past($countones(vld_q)));

  // R10
  no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_valid && ret_clear) |=> $countones(vld_q) >= $past($countones(vld_q)));

  // R9
  swept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_d |-> !(|stale));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ins_valid));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(ovf_wr && !ovf_wdata) |=> ovf_flag);

endmodule

bind hazard_table hazard_table_chk #(.DEPTH(DEPTH), .HW(HW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid),
  .chk_valid(chk_valid), .chk_handle(chk_handle), .chk_write(chk_write),
  .chk_ready(chk_ready), .ret_valid(ret_valid), .ret_clear(ret_clear),
  .ret_stamp(ret_stamp), .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata),
  .ovf_flag(ovf_flag), .vld_q(vld_q), .wr_q(wr_q), .hdl_q(hdl_q), .ts_q(ts_q)
);

// File: tb/tb_hazard_table.sv
module tb_hazard_table;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;

  logic        clk = 0, rst_n = 0;
  logic        ins_valid = 0, ins_write = 0;
  logic [63:0] ins_handle = '0;
  logic [31:0] ins_stamp = '0;
  logic        chk_valid = 0, chk_write = 0;
  logic [63:0] chk_handle = '0;
  logic        chk_ready;
  logic        ret_valid = 0, ret_clear = 0;
  logic [31:0] ret_stamp = '0;
  logic        ovf_wr = 0, ovf_wdata = 0;
  logic        ovf_flag;

  hazard_table dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;

  logic [63:0] m_h[DEPTH];
  logic [31:0] m_t[DEPTH];
  bit          m_w[DEPTH], m_v[DEPTH];
  bit          m_ovf;

  function automatic logic [63:0] hnd(int k);
    logic [63:0] b = 64'h3C00_0000_0000_0100 | (64'(k % 6) << 36) | 64'(k % 6);
    return (k >= 6) ? (b ^ 64'h8000_0000_0000_0000) : b;
  endfunction

  function automatic bit exp_ready();
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_h[i] == chk_handle && (m_w[i] || chk_write)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int hit, fr;
    bit set;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && ret_valid && ret_clear && m_t[i] <= ret_stamp) m_v[i] = 0;
    hit = -1; fr = -1; set = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && m_h[i] == ins_handle) hit = i;
      if (!m_v[i] && fr < 0) fr = i;
    end
    if (ins_valid) begin
      if (hit >= 0) begin
        m_t[hit] = ins_stamp;
        m_w[hit] = m_w[hit] | ins_write;
      end else if (fr >= 0) begin
        m_v[fr] = 1; m_h[fr] = ins_handle; m_w[fr] = ins_write; m_t[fr] = ins_stamp;
      end else set = 1;
    end
    if (set) m_ovf = 1;
    else if (ovf_wr && !ovf_wdata) m_ovf = 0;
  endtask

  // Called at a negedge with inputs set: compare, update model, advance one cycle.
  task automatic go(string tag);
    #1;
    check(tag, chk_ready, exp_ready(), "chk_ready");
    check(tag, ovf_flag, m_ovf, "ovf_flag");
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ins_valid = 0; ins_write = 0; ret_valid = 0; ret_clear = 0;
    ovf_wr = 0; ovf_wdata = 0; chk_valid = 0; chk_write = 0;
  endtask

  task automatic ins(logic [63:0] h, logic w, logic [31:0] t);
    idle(); ins_valid = 1; ins_handle = h; ins_write = w; ins_stamp = t;
  endtask

  task automatic probe(string tag, logic [63:0] h, logic w, logic exp);
    idle(); chk_valid = 1; chk_handle = h; chk_write = w;
    #1;
    check(tag, chk_ready, exp, "probe");
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_w[i] = 0; m_h[i] = '0; m_t[i] = '0; end
    m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    probe("R1", hnd(0), 1, 1); check("R1", ovf_flag, 0, "ovf after reset");
    go("R1");

    // R5 insert, R2/R3 check modes
    ins(hnd(0), 0, 10); go("R5");
    probe("R2", hnd(0), 1, 0);
    probe("R3", hnd(0), 0, 1);
    probe("R2", hnd(6), 1, 1);   // differs only in bit 63
    go("R3");

    // R6 merge: write flag ORed, stamp moved to 20
    ins(hnd(0), 1, 20); go("R6");
    probe("R6", hnd(0), 0, 0);
    idle(); ret_valid = 1; ret_clear = 1; ret_stamp = 19; go("R9");
    probe("R9", hnd(0), 0, 0);   // stamp 20 > 19 kept
    idle(); ret_valid = 1; ret_clear = 1; ret_stamp = 20; go("R9");
    probe("R9", hnd(0), 0, 1);   // equal stamp removed

    // R4 checks do not insert
    probe("R4", hnd(1), 1, 1); go("R4"); go("R4");
    probe("R4", hnd(1), 0, 1);

    // R10 completion without clear flag
    ins(hnd(2), 1, 5); go("R5");
    idle(); ret_valid = 1; ret_clear = 0; ret_stamp = 100; go("R10");
    probe("R10", hnd(2), 0, 0);

    // R9 no wraparound
    ins(hnd(3), 1, 32'hFFFF_FFF0); go("R5");
    idle(); ret_valid = 1; ret_clear = 1; ret_stamp = 6; go("R9");
    probe("R9", hnd(3), 0, 0);

    // R11 retire and insert same cycle
    ins(hnd(4), 1, 50); ret_valid = 1; ret_clear = 1; ret_stamp = 100; go("R11");
    probe("R11", hnd(2), 0, 1);
    probe("R11", hnd(4), 0, 0);

    // R7 overflow: 2 live entries, fill to 8 with merges in between
    for (int k = 7; k <= 12; k++) begin
      ins(hnd(k), 0, 200); go("R7");
      ins(hnd(k), 0, 201); go("R6");
    end
    check("R6", ovf_flag, 0, "merges keep ovf clear");
    ins(hnd(1), 1, 300); go("R7");
    check("R7", ovf_flag, 1, "ovf on full");
    probe("R7", hnd(1), 0, 1);

    // R8 sticky flag
    idle(); ovf_wr = 1; ovf_wdata = 1; go("R8");
    check("R8", ovf_flag, 1, "write one ignored");
    ins(hnd(5), 0, 300); ovf_wr = 1; ovf_wdata = 0; go("R8");
    check("R8", ovf_flag, 1, "set beats clear");
    idle(); ovf_wr = 1; ovf_wdata = 0; go("R8");
    check("R8", ovf_flag, 0, "write zero clears");

    // random phase
    begin
      logic [31:0] ts = 400;
      idle(); ret_valid = 1; ret_clear = 1; ret_stamp = 32'hFFFF_FFFF; go("R9");
      for (int n = 0; n < 3000; n++) begin
        idle();
        ts += $urandom_range(0, 3);
        ins_valid = ($urandom_range(0, 99) < 55);
        ins_handle = hnd($urandom_range(0, 11));
        ins_write = $urandom_range(0, 2) == 0;
        ins_stamp = ts;
        ret_valid = ($urandom_range(0, 99) < 20);
        ret_clear = $urandom_range(0, 3) != 0;
        ret_stamp = ts - $urandom_range(0, 8);
        ovf_wr = ($urandom_range(0, 99) < 4);
        ovf_wdata = $urandom_range(0, 1);
        chk_valid = 1;
        chk_handle = hnd($urandom_range(0, 11));
        chk_write = $urandom_range(0, 1);
        go("R2");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule